// File: doc/BRIEF.md
# Rotating-Parity Array Read Engine with Degraded Rebuild

This block serves block reads from an array of five independent memory channels, arranged so that every parity group holds four data blocks and one parity block. The parity block is the bitwise XOR of the four data blocks of its group. The channel that holds parity moves from one group to the next, which spreads channel bandwidth. A logical block address is split into a group number and a member index. The block then works out which channel owns the data and which channel holds that group's parity.

While the owning channel is healthy, the block sends one read to that channel and returns the word. Software can mark one channel as failed. If the failed channel owns the requested block, the block reads the other three data members and the parity block at the same time. It XORs their responses together in whatever order they return, then returns the rebuilt word with a flag set. The block handles one request at a time.

Top module: `rotpar_reader`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, no channel read is requested, and the failed-channel register reads as "no failure" (value 7).
- R2: The group is `g = req_lba[ADDR_W-1:2]` and the member is `m = req_lba[1:0]`. Parity for group g sits on channel `4 - (g mod 5)`. Member m lives on channel m when m is below the parity channel, and on channel m+1 otherwise. Every channel read carries row address g.
- R3: When the owning channel is not marked failed, exactly one read goes to the owning channel. `rsp_data` equals that channel's word and `rsp_rebuilt` is 0.
- R4: When the failed-channel register equals the owning channel, one read goes to each of the four other channels and none goes to the failed channel. `rsp_data` is the XOR of the four responses and `rsp_rebuilt` is 1.
- R5: In a rebuild, channel responses may arrive in any order, in different cycles or in the same cycle, and the result is still correct.
- R6: A one-cycle pulse on `fail_we` loads `fail_sel` into the failed-channel register. The values 5, 6 and 7 mean no failure. A failed parity channel, or any failed channel other than the owner, leaves reads of healthy data as single reads.
- R7: `rsp_valid` rises exactly OUT_LAT cycles after the cycle in which the last awaited channel response is presented.
- R8: `req_ready` stays low from the accepted request until the response is taken. While `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_rebuilt` hold steady.
- R9: A channel read request is held until that channel's `ch_req_ready` is seen, and each channel gets at most one read per request.
- R10: A response on a channel that has no accepted, unanswered read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_we | input | 1 | Write strobe for the failed-channel register |
| fail_sel | input | 3 | Failed channel number; 5 to 7 mean none |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_lba | input | ADDR_W | Logical block address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | DATA_W | Returned block |
| rsp_rebuilt | output | 1 | Block was rebuilt from survivors |
| ch_req_valid | output | 5 | Per-channel read request |
| ch_req_ready | input | 5 | Per-channel request accepted |
| ch_req_row | output | ADDR_W-2 | Row address (group number) for all channels |
| ch_rsp_valid | input | 5 | Per-channel response valid |
| ch_rsp_data | input | 5*DATA_W | Per-channel response words, channel c at bits c*DATA_W upward |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=8 and OUT_LAT=3. The 8-bit address gives 64 groups, so a short sweep covers every rotation of the parity channel and every member position, including the members above the parity slot. OUT_LAT=3 puts the delay counter through more than one step, so a count that is off by one shows up as a latency error. 32-bit words that are distinct for each group and member mean a wrong channel, a wrong row or a missing XOR term gives a different result.

// File: rtl/rotpar_reader.sv
module rotpar_reader #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int OUT_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fail_we,
  input  logic [2:0]            fail_sel,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_lba,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_rebuilt,
  output logic [4:0]            ch_req_valid,
  input  logic [4:0]            ch_req_ready,
  output logic [ADDR_W-3:0]     ch_req_row,
  input  logic [4:0]            ch_rsp_valid,
  input  logic [5*DATA_W-1:0]   ch_rsp_data
);
  localparam int ROW_W = ADDR_W - 2;
  localparam int CNT_W = (OUT_LAT < 2) ? 1 : $clog2(OUT_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_OUT} st_t;

  st_t               st;
  logic [2:0]        fail_q;
  logic [4:0]        iss_q, pend_q;
  logic [DATA_W-1:0] acc_q;
  logic [ROW_W-1:0]  row_q;
  logic              deg_q;
  logic [CNT_W-1:0]  cnt_q;

  // address decode
  logic [ROW_W-1:0] grp;
  logic [2:0]       g_mod, par_ch, dat_ch, mem3;
  logic [4:0]       dat_oh, rd_mask;
  logic             degr;

  assign grp     = req_lba[ADDR_W-1:2];
  assign g_mod   = 3'(grp % 5);
  assign par_ch  = 3'd4 - g_mod;
  assign mem3    = {1'b0, req_lba[1:0]};
  assign dat_ch  = (mem3 < par_ch) ? mem3 : mem3 + 3'd1;
  assign dat_oh  = 5'd1 << dat_ch;
  assign degr    = (fail_q == dat_ch);
  assign rd_mask = degr ? ~dat_oh : dat_oh;

  // response collection
  logic [4:0]        take, pend_nx;
  logic [DATA_W-1:0] xin;

  assign take    = ch_rsp_valid & pend_q & ~iss_q;
  assign pend_nx = pend_q & ~take;

  always_comb begin
    xin = '0;
    for (int i = 0; i < 5; i++)
      if (take[i]) xin = xin ^ ch_rsp_data[i*DATA_W +: DATA_W];
  end

  assign req_ready    = (st == S_IDLE);
  assign rsp_valid    = (st == S_OUT);
  assign rsp_data     = acc_q;
  assign rsp_rebuilt  = deg_q;
  assign ch_req_valid = iss_q;
  assign ch_req_row   = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      fail_q <= 3'd7;
      iss_q  <= '0;
      pend_q <= '0;
      acc_q  <= '0;
      row_q  <= '0;
      deg_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (fail_we) fail_q <= fail_sel;
      case (st)
        S_IDLE: if (req_valid) begin
          row_q  <= grp;
          iss_q  <= rd_mask;
          pend_q <= rd_mask;
          acc_q  <= '0;
          deg_q  <= degr;
          st     <= S_READ;
        end
        S_READ: begin
          iss_q  <= iss_q & ~ch_req_ready;
          pend_q <= pend_nx;
          acc_q  <= acc_q ^ xin;
          if (pend_nx == 5'd0) begin
            if (OUT_LAT <= 1) st <= S_OUT;
            else begin
              st    <= S_WAIT;
              cnt_q <= CNT_W'(OUT_LAT - 1);
            end
          end
        end
        S_WAIT: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st <= S_OUT;
        end
        S_OUT: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] chv8;
  assign chv8 = {3'b000, ch_req_valid};

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_rebuilt)); // R8
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid); // R8
  AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid & ~ch_req_ready) != 5'd0 |=> ($past(ch_req_valid & ~ch_req_ready) & ~ch_req_valid) == 5'd0); // R9
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid & ch_req_ready) != 5'd0 |=> ($past(ch_req_valid & ch_req_ready) & ch_req_valid) == 5'd0); // R9
  AST_HEALTHY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (fail_q != dat_ch) |=> $countones(ch_req_valid) == 1 && !rsp_rebuilt); // R3
  AST_DEGR_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (fail_q == dat_ch) |=> $countones(ch_req_valid) == 4 && !chv8[$past(fail_q)] && rsp_rebuilt); // R4
endmodule

// File: tb/sim_rotpar_reader.sv
module sim_rotpar_reader;
  localparam int DW = 32, AW = 8, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fail_we = 1'b0;
  logic [2:0] fail_sel = 3'd7;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_lba = '0;
  logic req_ready, rsp_valid, rsp_rebuilt;
  logic [DW-1:0] rsp_data;
  logic [4:0] ch_req_valid, ch_rsp_valid;
  logic [4:0] crdy = 5'h1F;
  logic [AW-3:0] ch_req_row;
  logic [5*DW-1:0] chd;

  int checks = 0, fails = 0;
  int cyc = 0, last_rv = 0;
  int ch_dly [5];
  int bad_ch = 9;
  int nreads [5];
  int lastrow [5];
  int cntd [5];
  logic busy [5];
  logic [4:0] rv = '0, spur_v = '0, spur_m = '0, hold_m = '0;
  int spur_cyc = -1, hold_until = -1;
  logic [DW-1:0] rd [5];

  always #5 clk = ~clk;

  rotpar_reader #(.DATA_W(DW), .ADDR_W(AW), .OUT_LAT(LAT)) u0 (
    .clk, .rst_n, .fail_we, .fail_sel, .req_valid, .req_ready, .req_lba,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_rebuilt,
    .ch_req_valid, .ch_req_ready(crdy), .ch_req_row,
    .ch_rsp_valid, .ch_rsp_data(chd));

  function automatic logic [31:0] blk(int g, int m);
    return (32'(g) * 32'h9E3779B1) ^ ((32'(m) + 32'd1) * 32'h7F4A7C15);
  endfunction
  function automatic int par_of(int g); return 4 - (g % 5); endfunction
  function automatic int own_of(int lba);
    int p = par_of(lba / 4), m = lba % 4;
    return (m < p) ? m : m + 1;
  endfunction
  function automatic logic [31:0] chan_word(int c, int g);
    int p = par_of(g);
    if (c == p) return blk(g,0) ^ blk(g,1) ^ blk(g,2) ^ blk(g,3);
    return blk(g, (c < p) ? c : c - 1);
  endfunction

  assign ch_rsp_valid = rv | spur_v;
  always_comb
    for (int c = 0; c < 5; c++)
      chd[c*DW +: DW] = spur_v[c] ? (32'hBAD00000 | 32'(c)) : rd[c];

  initial for (int c = 0; c < 5; c++) begin
    nreads[c] = 0; busy[c] = 1'b0; cntd[c] = 0; rd[c] = '0; ch_dly[c] = 0; lastrow[c] = -1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < 5; c++) begin
      if (rv[c]) rv[c] <= 1'b0;
      if (ch_req_valid[c] && crdy[c]) begin
        nreads[c]  <= nreads[c] + 1;
        lastrow[c] <= int'(ch_req_row);
        busy[c]    <= 1'b1;
        cntd[c]    <= ch_dly[c];
      end else if (busy[c]) begin
        if (cntd[c] == 0) begin
          rv[c]   <= 1'b1;
          rd[c]   <= chan_word(c, lastrow[c]) ^ ((c == bad_ch) ? 32'hDEADBEEF : 32'h0);
          busy[c] <= 1'b0;
        end else cntd[c] <= cntd[c] - 1;
      end
    end
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual cycle %0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (|rv) last_rv <= cyc;
    spur_v <= (cyc == spur_cyc) ? spur_m : 5'd0;
    crdy   <= (cyc < hold_until) ? ~hold_m : 5'h1F;
  end

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic set_fail(logic [2:0] v);
    @(negedge clk); fail_we = 1'b1; fail_sel = v;
    @(negedge clk); fail_we = 1'b0;
  endtask

  task automatic do_read(int lba, bit deg);
    int base [5];
    int g = lba / 4, own = own_of(lba), t0, lat;
    logic [4:0] got_m = '0, exp_m;
    logic [DW-1:0] got;
    logic reb;
    for (int c = 0; c < 5; c++) base[c] = nreads[c];
    @(negedge clk); req_valid = 1'b1; req_lba = AW'(lba);
    @(negedge clk); req_valid = 1'b0;
    t0 = cyc;
    while (!rsp_valid && cyc - t0 < 200) @(negedge clk);
    got = rsp_data; reb = rsp_rebuilt; lat = cyc - last_rv;
    @(negedge clk);
    for (int c = 0; c < 5; c++) got_m[c] = (nreads[c] - base[c]) == 1;
    for (int c = 0; c < 5; c++) if (nreads[c] - base[c] > 1) got_m = 5'h00;
    exp_m = deg ? (5'h1F & ~(5'd1 << own)) : (5'd1 << own);
    chk(got == blk(g, lba % 4), deg ? "R4 R5 rebuilt data" : "R3 healthy data", got, blk(g, lba % 4));
    chk(got_m == exp_m, "R2 R3 R4 R9 channels read", 32'(got_m), 32'(exp_m));
    chk(lastrow[deg ? (own + 1) % 5 : own] == g, "R2 row address",
        32'(lastrow[deg ? (own + 1) % 5 : own]), 32'(g));
    chk(reb == deg, "R3 R4 rebuilt flag", 32'(reb), 32'(deg));
    chk(lat == LAT, "R7 output latency", 32'(lat), 32'(LAT));
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(ch_req_valid == 5'd0, "R1 ch_req_valid", 32'(ch_req_valid), 32'd0);
    do_read(5, 1'b0); // R1: default register means no failure
  endtask

  task automatic t_healthy;
    for (int c = 0; c < 5; c++) ch_dly[c] = c * 2;
    for (int a = 0; a < 44; a++) do_read(a, 1'b0); // R2 all rotations
    do_read(255, 1'b0);
  endtask

  task automatic t_degraded;
    int lbas [6] = '{0, 7, 13, 18, 22, 39};
    foreach (lbas[i]) begin
      int own = own_of(lbas[i]);
      for (int c = 0; c < 5; c++) ch_dly[c] = (c * 3 + i) % 7; // R5 scrambled order
      set_fail(3'(own)); bad_ch = own;
      do_read(lbas[i], 1'b1);
    end
    for (int c = 0; c < 5; c++) ch_dly[c] = 0; // R5 same cycle
    set_fail(3'(own_of(30))); bad_ch = own_of(30);
    do_read(30, 1'b1);
  endtask

  task automatic t_parity_fail; // R6
    for (int c = 0; c < 5; c++) ch_dly[c] = 1;
    for (int g = 3; g < 8; g++) begin
      set_fail(3'(par_of(g))); bad_ch = par_of(g);
      for (int m = 0; m < 4; m++) do_read(g * 4 + m, 1'b0);
    end
    set_fail(3'(own_of(9) == 0 ? 1 : 0)); bad_ch = own_of(9) == 0 ? 1 : 0;
    do_read(9, 1'b0);
  endtask

  task automatic t_nofail_codes; // R6
    bad_ch = 9;
    for (int v = 5; v < 8; v++) begin
      set_fail(3'(v));
      do_read(v * 4 + 1, 1'b0);
    end
  endtask

  task automatic t_backpressure; // R8
    logic [DW-1:0] d0;
    int t0;
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_lba = 8'd50;
    @(negedge clk); req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
    t0 = cyc;
    while (!rsp_valid && cyc - t0 < 200) @(negedge clk);
    d0 = rsp_data;
    chk(d0 == blk(12, 2), "R8 data under backpressure", d0, blk(12, 2));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == d0 && !req_ready, "R8 held response",
          {rsp_valid, req_ready, rsp_data[29:0]}, {2'b10, d0[29:0]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 release", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_chready; // R9
    int own = own_of(26);
    set_fail(3'(own)); bad_ch = own;
    for (int c = 0; c < 5; c++) ch_dly[c] = 1;
    hold_m = 5'h1F & ~(5'd1 << own) & ~5'd1;
    hold_until = cyc + 8;
    do_read(26, 1'b1);
    hold_m = (5'd1 << own_of(11)); set_fail(3'd7); bad_ch = 9;
    hold_until = cyc + 6;
    do_read(11, 1'b0);
  endtask

  task automatic t_spur; // R10
    int own = own_of(45);
    for (int c = 0; c < 5; c++) ch_dly[c] = 8;
    spur_m = 5'h1F & ~(5'd1 << own);
    spur_cyc = cyc + 4;
    do_read(45, 1'b0);
    own = own_of(62);
    set_fail(3'(own)); bad_ch = own;
    spur_m = 5'd1 << own;
    spur_cyc = cyc + 5;
    do_read(62, 1'b1);
    spur_cyc = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_healthy();
    t_degraded();
    t_parity_fail();
    t_nofail_codes();
    t_backpressure();
    t_chready();
    t_spur();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule